// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block adds two N-bit operands and a carry input without any clock, in three phases. First, each bit position forms its own propagate (operand XOR) and generate (operand AND). The carry input is folded into the generate of bit 0. Second, a network of identical two-input group cells computes, for every bit position i, the group generate of bits i down to 0. Third, each sum bit is the bit propagate XORed with the carry coming out of the bits below it.

A single parameter picks the shape of the prefix network. Every shape is built from the same group cell, so they differ only in wiring. The shapes trade logic depth against fan-out and cell count:

| Encoding | Shape | Levels | Fan-out |
|---|---|---|---|
| 0 | Sparse | 2·log2(N)−1 (up-sweep, then down-sweep) | 2 |
| 1 | Minimum-depth | log2(N) | Doubles at each level |
| 2 | Full-density | log2(N) | 2 (most cells and wires) |
| 3 | Hybrid | log2(N)+1 (full-density on odd bits, one extra level for even bits) | 2 |

A topology value outside 0..3, a width that is not a power of two, or a width below 2 stops elaboration.

Top module: `pfx_adder`

## Requirements
- R1: {cout_o, sum_o} equals a_i + b_i + cin_i taken as an (N+1)-bit unsigned sum, for any operands and any legal topology.
- R2: With TOPO = 0 (sparse: up-sweep then down-sweep, 2·log2(N)−1 levels), the result satisfies R1.
- R3: With TOPO = 1 (minimum-depth: log2(N) levels, fan-out doubling per level), the result satisfies R1.
- R4: With TOPO = 2 (full-density: log2(N) levels, fan-out 2), the result satisfies R1.
- R5: With TOPO = 3 (hybrid: full-density on odd bits plus one final level into even bits), the result satisfies R1.
- R6: sum_o[i] equals (a_i[i] XOR b_i[i]) XOR the carry into bit i, and the carry into bit 0 is cin_i. With both operands zero, sum_o equals cin_i in bit 0 and zero elsewhere.
- R7: The carry into bit i+1 equals g[i] OR (p[i] AND carry into bit i), where g is the operand AND and p is the operand XOR. A carry entering at bit 0 must ripple to cout_o through all N bits: all ones plus zero with cin_i = 1 gives sum_o = 0 and cout_o = 1.
- R8: When every bit propagates (a_i XOR b_i is all ones), cout_o equals cin_i and sum_o equals the inverse of cin_i replicated across all bits.
- R9: When a_i[N−1] and b_i[N−1] are both 1, cout_o is 1. All ones plus all ones plus 1 gives sum_o all ones and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N−1 |

## Verification
Every result is combinational, so each is due in the same cycle as the operands that produce it; the design adds no register on the path. The bench instantiates all four topologies side by side. Its driver applies an operand set just after a rising clock edge and queues the expected value. The monitor pops that value at the next falling edge, half a period later, and compares it against each instance, so every comparison sees settled outputs of the vector it belongs to.

// File: rtl/pfx_adder_pkg.sv
package pfx_adder_pkg;

  localparam int unsigned TOPO_SPARSE    = 0;
  localparam int unsigned TOPO_MIN_DEPTH = 1;
  localparam int unsigned TOPO_FULL      = 2;
  localparam int unsigned TOPO_HYBRID    = 3;

  function automatic int log2_of(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  function automatic int num_stages(input int topo, input int lg);
    case (topo)
      TOPO_SPARSE:    return (lg > 1) ? 2 * lg - 1 : 1;
      TOPO_MIN_DEPTH: return lg;
      TOPO_FULL:      return lg;
      default:        return lg + 1;
    endcase
  endfunction

  // Lower-group index combined into node i at stage s, or -1 to pass through.
  function automatic int partner(input int topo, input int lg, input int s, input int i);
    int l;
    case (topo)
      TOPO_SPARSE: begin
        if (s < lg) begin
          l = s;
          if (((i + 1) % (1 << (l + 1))) == 0) return i - (1 << l);
        end else begin
          l = 2 * lg - 2 - s;
          if ((((i + 1) % (1 << (l + 1))) == (1 << l)) && (i >= (1 << (l + 1))))
            return i - (1 << l);
        end
      end
      TOPO_MIN_DEPTH: begin
        l = s;
        if (((i >> l) & 1) == 1) return ((i >> l) << l) - 1;
      end
      TOPO_FULL: begin
        if (i >= (1 << s)) return i - (1 << s);
      end
      default: begin
        if (s < lg) begin
          if ((i % 2 == 1) && (i >= (1 << s))) return i - (1 << s);
        end else begin
          if ((i % 2 == 0) && (i > 0)) return i - 1;
        end
      end
    endcase
    return -1;
  endfunction

endpackage

// File: rtl/pfx_pg_cell.sv
module pfx_pg_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/pfx_bit_pg.sv
module pfx_bit_pg #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] p_o,
  output logic [N-1:0] g_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    if (i == 0) begin : g_fold
      // carry input acts as the generate of bit -1
      assign g_o[i] = (a_i[i] & b_i[i]) | (p_o[i] & cin_i);
    end else begin : g_plain
      assign g_o[i] = a_i[i] & b_i[i];
    end
  end
endmodule

// File: rtl/pfx_prefix_net.sv
module pfx_prefix_net #(
  parameter int unsigned N    = 32,
  parameter int unsigned TOPO = 0
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] grp_g_o
);
  import pfx_adder_pkg::*;

  localparam int LG = log2_of(N);
  localparam int NS = num_stages(TOPO, LG);

  logic [NS:0][N-1:0] g_lv;
  logic [NS:0][N-1:0] p_lv;

  assign g_lv[0] = g_i;
  assign p_lv[0] = p_i;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_node
      localparam int J = partner(TOPO, LG, s, i);
      if (J >= 0) begin : g_cell
        pfx_pg_cell u_cell (
          .g_hi_i (g_lv[s][i]),
          .p_hi_i (p_lv[s][i]),
          .g_lo_i (g_lv[s][J]),
          .p_lo_i (p_lv[s][J]),
          .g_o    (g_lv[s+1][i]),
          .p_o    (p_lv[s+1][i])
        );
      end else begin : g_pass
        assign g_lv[s+1][i] = g_lv[s][i];
        assign p_lv[s+1][i] = p_lv[s][i];
      end
    end
  end

  assign grp_g_o = g_lv[NS];

  logic unused_p;
  assign unused_p = ^p_lv;
endmodule

// File: rtl/pfx_sum_xor.sv
module pfx_sum_xor #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] carry_i,
  output logic [N-1:0] sum_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum_o[i] = p_i[i] ^ carry_i[i];
  end
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
  parameter int unsigned N    = 32,
  parameter int unsigned TOPO = 0
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  if ((TOPO > 3) || (N < 2) || ((N & (N - 1)) != 0)) begin : g_bad_cfg
    $error("pfx_adder: illegal N or TOPO");
  end

  logic [N-1:0] p_bit;
  logic [N-1:0] g_bit;
  logic [N-1:0] grp_g;
  logic [N-1:0] carry;

  pfx_bit_pg #(.N(N)) u_bit_pg (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .p_o   (p_bit),
    .g_o   (g_bit)
  );

  pfx_prefix_net #(.N(N), .TOPO(TOPO)) u_net (
    .g_i     (g_bit),
    .p_i     (p_bit),
    .grp_g_o (grp_g)
  );

  assign carry  = {grp_g[N-2:0], cin_i};
  assign cout_o = grp_g[N-1];

  pfx_sum_xor #(.N(N)) u_sum (
    .p_i     (p_bit),
    .carry_i (carry),
    .sum_o   (sum_o)
  );
endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
  parameter int unsigned N = 32
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         cin_i,
  input logic [N-1:0] sum_o,
  input logic         cout_o,
  input logic [N-1:0] carry
);
  logic [N:0] ref_w;
  assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      assert_ref_sum_R1: assert ({cout_o, sum_o} == ref_w)
        else $error("R1 adder result mismatch");
      assert_bit_sum_R6: assert (sum_o == ((a_i ^ b_i) ^ carry))
        else $error("R6 sum bit not propagate xor carry");
      for (int i = 0; i < N - 1; i++) begin
        assert_ripple_R7: assert (carry[i+1] ==
            ((a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & carry[i])))
          else $error("R7 carry recurrence broken at bit %0d", i);
      end
      if (&(a_i ^ b_i)) begin
        assert_all_prop_R8: assert (cout_o == cin_i)
          else $error("R8 full propagate cout");
      end
      if (a_i[N-1] & b_i[N-1]) begin
        assert_msb_gen_R9: assert (cout_o)
          else $error("R9 msb generate cout");
      end
    end
  end
endmodule

bind pfx_adder pfx_adder_chk #(.N(N)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .carry  (carry)
);

// File: tb/tb_pfx_adder.sv
`timescale 1ns/1ps
module tb_pfx_adder;
  localparam int unsigned N = 32;
  localparam int NT = 4;

  typedef struct {
    logic [N-1:0] s;
    logic         c;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] a_d = '0;
  logic [N-1:0] b_d = '0;
  logic         cin_d = 1'b0;

  logic [N-1:0] sum_w [NT];
  logic         cout_w [NT];

  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  string topo_tag [NT] = '{"R2", "R3", "R4", "R5"};

  always #4 clk = ~clk;

  for (genvar t = 0; t < NT; t++) begin : g_top
    pfx_adder #(.N(N), .TOPO(t)) dut (
      .a_i    (a_d),
      .b_i    (b_d),
      .cin_i  (cin_d),
      .sum_o  (sum_w[t]),
      .cout_o (cout_w[t])
    );
  end

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic cin, input string req);
    logic [N:0] full;
    exp_t e;
    @(posedge clk);
    #1;
    a_d = a; b_d = b; cin_d = cin;
    full = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
    e.s = full[N-1:0];
    e.c = full[N];
    e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: results are combinational, due half a period after drive
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        for (int t = 0; t < NT; t++) begin
          checks++;
          if (sum_w[t] !== e.s || cout_w[t] !== e.c) begin
            fails++;
            $display("FAIL %s/%s topo=%0d a=%h b=%h cin=%0b actual=%0b_%h expected=%0b_%h",
                     e.req, topo_tag[t], t, a_d, b_d, cin_d,
                     cout_w[t], sum_w[t], e.c, e.s);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: zero operands
    drive('0, '0, 1'b0, "R1_reset");
    // R6: zero operands pass cin into bit 0 only
    drive('0, '0, 1'b1, "R6");
    // R7: carry ripples from bit 0 out through every bit
    drive('1, '0, 1'b1, "R7");
    drive('0, '1, 1'b1, "R7");
    drive({N{1'b1}}, {{(N-1){1'b0}}, 1'b1}, 1'b0, "R7");
    // R8: every bit propagates, cout follows cin
    drive({(N/2){2'b01}}, {(N/2){2'b10}}, 1'b0, "R8");
    drive({(N/2){2'b01}}, {(N/2){2'b10}}, 1'b1, "R8");
    drive({(N/2){2'b10}}, {(N/2){2'b01}}, 1'b1, "R8");
    // R9: MSB generate and maximum operands
    drive('1, '1, 1'b1, "R9");
    drive('1, '1, 1'b0, "R9");
    drive({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, 1'b0, "R9");
    // walking generate positions
    for (int k = 0; k < N; k++) begin
      drive(N'(1) << k, N'(1) << k, 1'b0, "R7_walk");
      drive((N'(1) << k) | ((N'(1) << k) - N'(1)), N'(1), 1'b0, "R7_walk");
    end
    // R1: random operands
    for (int k = 0; k < 3000; k++) begin
      drive(N'($urandom()), N'($urandom()), 1'($urandom()), "R1_rand");
    end
    // R1: random with long propagate runs
    for (int k = 0; k < 1000; k++) begin
      logic [N-1:0] ra;
      ra = N'($urandom());
      drive(ra, ~ra ^ (N'(1) << ($urandom() % N)), 1'($urandom()), "R1_long");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule